// File: doc/BRIEF.md
# Card Presence and Reset Controller

This block watches the two active-low card-detect pins of a removable card slot and decides whether a card is fully seated. It raises a one-cycle change event each time that decision flips. When a card arrives, it holds the card in reset for a fixed number of clock cycles and then releases it. The pins pass through a two-flop synchronizer and a debounce counter before the presence decision is taken. A card that is already in the slot when reset is released therefore produces exactly one insertion event.

The block also owns the slot's operation-mode register: the interface mode, the card type, a software card-reset bit, a host-enable bit and an output-tristate bit. The card reset output is driven whenever the software bit is set or the automatic insertion pulse is running. While host enable is clear, the controller soft-reset output is held high, so that the transfer logic stays idle. Clearing host enable and then setting it again therefore resets that logic.

The presence machine has three states. ST_EMPTY is the reset state. ST_RESETTING runs the insertion pulse. ST_SEATED means a card is present with reset released. Its transitions are:
- INSERT: ST_EMPTY to ST_RESETTING, taken when debounced presence appears. It raises the event.
- PULSE_DONE: ST_RESETTING to ST_SEATED, taken after the pulse length has elapsed.
- PULL_EARLY: ST_RESETTING to ST_EMPTY, taken when presence is lost mid-pulse. It raises the event.
- REMOVE: ST_SEATED to ST_EMPTY, taken when debounced presence is lost. It raises the event.

Top module: `card_presence_ctrl`

## Requirements
- R1: A card counts as present only when both detect pins are low. One pin low on its own never makes the card present.
- R2: A change in pin level must persist for DEB_CYCLES consecutive cycles after the synchronizer before presence updates. The event appears DEB_CYCLES+3 clock edges after the pins change. A shorter pulse on the pins is ignored.
- R3: `chg_evt_o` is high for exactly one cycle, in the cycle in which `present_o` changes, for both insertion and removal. It stays low while presence is steady.
- R4: On insertion, `card_rst_o` rises in the same cycle as the event. It stays high for exactly RST_CYCLES cycles, after which the state is ST_SEATED.
- R5: If presence is lost during the insertion pulse, the machine returns to ST_EMPTY with an event, and the automatic pulse ends at once.
- R6: `card_rst_o` is the OR of operation-mode bit 3 (the software card reset) and the automatic insertion pulse.
- R7: The operation-mode register is at byte address 0x00C. Its fields are: bits 1:0 mode, bit 2 card type, bit 3 card reset, bit 4 host enable, bit 5 output tristate. Higher bits read as 0. The register resets to 0. Writes to any other address leave it unchanged.
- R8: `ctrl_srst_o` is high exactly while host enable (bit 4) is 0, including directly after reset.
- R9: The status register is at address 0x000. Its fields are: bit 0 present, bit 2 synchronized detect A level, bit 3 synchronized detect B level, bit 5 card ready, bit 6 I/O ready. All other bits are 0.
- R10: Presence resets to absent. A card present at power-up gives exactly one insertion event, DEB_CYCLES+3 edges after reset is released.
- R11: Reads of any address other than 0x000 and 0x00C return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_a_n | input | 1 | Card detect A, active low |
| det_b_n | input | 1 | Card detect B, active low |
| card_rdy_i | input | 1 | Card ready level from the slot |
| io_rdy_i | input | 1 | I/O ready level from the slot |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational on address) |
| card_rst_o | output | 1 | Card reset to the slot |
| ctrl_srst_o | output | 1 | Soft reset to the transfer logic |
| chg_evt_o | output | 1 | One-cycle presence change event |
| present_o | output | 1 | Card presence state |
| mode_o | output | 2 | Interface mode field |
| card_type_o | output | 1 | Card type bit |
| tristate_o | output | 1 | Output tristate request |

## Verification
The hardest situation to reach from the ports is a removal that lands inside the insertion reset pulse. The pins must be released during a window that the debounce latency narrows. The bench inserts a card, waits three cycles after the event and then releases both pins. With the short pulse length the bench uses, the removal event is due while the pulse would still be running. At that point `card_rst_o` must already be low. Glitch rejection is reached by holding both pins low for one cycle fewer than the debounce length. A second reset is applied with the card inserted, to reach the power-up case.

// File: rtl/cpr_pkg.sv
`timescale 1ns/1ps
package cpr_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY     = 2'd0,
        ST_RESETTING = 2'd1,
        ST_SEATED    = 2'd2
    } card_state_e;

    localparam int          REG_AW      = 12;
    localparam logic [11:0] ADDR_STATUS = 12'h000;
    localparam logic [11:0] ADDR_OPMODE = 12'h00C;

    // operation-mode field layout
    localparam int OPM_W        = 6;
    localparam int OPM_TYPE_BIT = 2;
    localparam int OPM_RST_BIT  = 3;
    localparam int OPM_HOST_BIT = 4;
    localparam int OPM_TRI_BIT  = 5;

    // status field layout
    localparam int STS_PRESENT = 0;
    localparam int STS_DET_A   = 2;
    localparam int STS_DET_B   = 3;
    localparam int STS_CRDY    = 5;
    localparam int STS_IORDY   = 6;
endpackage

// File: rtl/cpr_sync.sv
`timescale 1ns/1ps
module cpr_sync #(
    parameter int         W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/cpr_debounce.sv
`timescale 1ns/1ps
module cpr_debounce #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic stable_o
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_q;
    logic          stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            stable_q <= 1'b0;
        end else if (raw_i == stable_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(CYCLES - 1)) begin
            stable_q <= raw_i;
            cnt_q    <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stable_o = stable_q;
endmodule

// File: rtl/cpr_presence_fsm.sv
`timescale 1ns/1ps
module cpr_presence_fsm
    import cpr_pkg::*;
#(
    parameter int RST_CYCLES = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic present_i,
    output logic evt_o,
    output logic pulse_o,
    output logic seated_o
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    card_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          evt_q, evt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        evt_d   = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (present_i) begin          // INSERT
                    state_d = ST_RESETTING;
                    cnt_d   = '0;
                    evt_d   = 1'b1;
                end
            end
            ST_RESETTING: begin
                if (!present_i) begin         // PULL_EARLY
                    state_d = ST_EMPTY;
                    evt_d   = 1'b1;
                end else if (cnt_q == CW'(RST_CYCLES - 1)) begin
                    state_d = ST_SEATED;      // PULSE_DONE
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SEATED: begin
                if (!present_i) begin         // REMOVE
                    state_d = ST_EMPTY;
                    evt_d   = 1'b1;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
            evt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            evt_q   <= evt_d;
        end
    end

    always_comb begin
        evt_o    = evt_q;
        pulse_o  = (state_q == ST_RESETTING);
        seated_o = (state_q != ST_EMPTY);
    end
endmodule

// File: rtl/cpr_opmode_regs.sv
`timescale 1ns/1ps
module cpr_opmode_regs
    import cpr_pkg::*;
#(
    parameter int AW = REG_AW,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          present_i,
    input  logic          det_a_i,
    input  logic          det_b_i,
    input  logic          card_rdy_i,
    input  logic          io_rdy_i,
    output logic [DW-1:0] rdata_o,
    output logic [OPM_W-1:0] opm_o
);
    logic [OPM_W-1:0] opm_q;
    logic             unused_wdata;

    assign unused_wdata = ^wdata_i[DW-1:OPM_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opm_q <= '0;
        end else if (wen_i && (addr_i == AW'(ADDR_OPMODE))) begin
            opm_q <= wdata_i[OPM_W-1:0];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(ADDR_STATUS)) begin
            rdata_o[STS_PRESENT] = present_i;
            rdata_o[STS_DET_A]   = det_a_i;
            rdata_o[STS_DET_B]   = det_b_i;
            rdata_o[STS_CRDY]    = card_rdy_i;
            rdata_o[STS_IORDY]   = io_rdy_i;
        end else if (addr_i == AW'(ADDR_OPMODE)) begin
            rdata_o[OPM_W-1:0] = opm_q;
        end
    end

    assign opm_o = opm_q;
endmodule

// File: rtl/card_presence_ctrl.sv
`timescale 1ns/1ps
module card_presence_ctrl
    import cpr_pkg::*;
#(
    parameter int AW         = REG_AW,
    parameter int DW         = 32,
    parameter int DEB_CYCLES = 16,
    parameter int RST_CYCLES = 40000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          det_a_n,
    input  logic          det_b_n,
    input  logic          card_rdy_i,
    input  logic          io_rdy_i,
    input  logic          reg_wen,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          card_rst_o,
    output logic          ctrl_srst_o,
    output logic          chg_evt_o,
    output logic          present_o,
    output logic [1:0]    mode_o,
    output logic          card_type_o,
    output logic          tristate_o
);
    // synchronized bits: {io_rdy, card_rdy, det_b_n, det_a_n}
    logic [3:0]       sync_lv;
    logic             both_low;
    logic             deb_present;
    logic             auto_pulse;
    logic             seated;
    logic             evt;
    logic [OPM_W-1:0] opm;

    cpr_sync #(.W(4), .RST_VAL(4'b0011)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({io_rdy_i, card_rdy_i, det_b_n, det_a_n}),
        .sync_o  (sync_lv)
    );

    assign both_low = ~sync_lv[0] & ~sync_lv[1];

    cpr_debounce #(.CYCLES(DEB_CYCLES)) u_deb (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (both_low),
        .stable_o (deb_present)
    );

    cpr_presence_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .present_i (deb_present),
        .evt_o     (evt),
        .pulse_o   (auto_pulse),
        .seated_o  (seated)
    );

    cpr_opmode_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wen_i      (reg_wen),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .present_i  (seated),
        .det_a_i    (sync_lv[0]),
        .det_b_i    (sync_lv[1]),
        .card_rdy_i (sync_lv[2]),
        .io_rdy_i   (sync_lv[3]),
        .rdata_o    (reg_rdata),
        .opm_o      (opm)
    );

    assign card_rst_o  = opm[OPM_RST_BIT] | auto_pulse;
    assign ctrl_srst_o = ~opm[OPM_HOST_BIT];
    assign chg_evt_o   = evt;
    assign present_o   = seated;
    assign mode_o      = opm[1:0];
    assign card_type_o = opm[OPM_TYPE_BIT];
    assign tristate_o  = opm[OPM_TRI_BIT];
endmodule

// File: rtl/cpr_checker.sv
`timescale 1ns/1ps
module cpr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wen,
    input logic [11:0] reg_addr,
    input logic [5:0]  wr_bits,
    input logic        card_rst_o,
    input logic        ctrl_srst_o,
    input logic        chg_evt_o,
    input logic        present_o
);
    // R3
    evt_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_evt_o |-> (present_o != $past(present_o)));

    // R3
    change_has_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (present_o != $past(present_o)) |-> chg_evt_o);

    // R4
    insert_starts_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(present_o) |-> card_rst_o);

    // R6
    sw_reset_drives_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == 12'h00C && wr_bits[3]) |=> card_rst_o);

    // R8
    host_off_soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == 12'h00C && !wr_bits[4]) |=> ctrl_srst_o);

    // R8
    host_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == 12'h00C && wr_bits[4]) |=> !ctrl_srst_o);
endmodule

bind card_presence_ctrl cpr_checker u_cpr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wen     (reg_wen),
    .reg_addr    (reg_addr[11:0]),
    .wr_bits     (reg_wdata[5:0]),
    .card_rst_o  (card_rst_o),
    .ctrl_srst_o (ctrl_srst_o),
    .chg_evt_o   (chg_evt_o),
    .present_o   (present_o)
);

// File: tb/card_presence_ctrl_test.sv
`timescale 1ns/1ps
module card_presence_ctrl_test;
    localparam int DEB = 4;
    localparam int RST = 12;
    localparam int LAT = DEB + 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        det_a_n = 1'b1, det_b_n = 1'b1;
    logic        card_rdy_i = 1'b0, io_rdy_i = 1'b0;
    logic        reg_wen = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        card_rst_o, ctrl_srst_o, chg_evt_o, present_o;
    logic [1:0]  mode_o;
    logic        card_type_o, tristate_o;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    card_presence_ctrl #(.DEB_CYCLES(DEB), .RST_CYCLES(RST)) uut (
        .clk(clk), .rst_n(rst_n), .det_a_n(det_a_n), .det_b_n(det_b_n),
        .card_rdy_i(card_rdy_i), .io_rdy_i(io_rdy_i), .reg_wen(reg_wen),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .card_rst_o(card_rst_o), .ctrl_srst_o(ctrl_srst_o), .chg_evt_o(chg_evt_o),
        .present_o(present_o), .mode_o(mode_o), .card_type_o(card_type_o),
        .tristate_o(tristate_o)
    );

    // register vectors: address, write data, expected opmode readback, card_rst, ctrl_srst
    localparam int NV = 8;
    localparam logic [11:0] V_ADDR [0:NV-1] = '{12'h00C, 12'h00C, 12'h00C, 12'h000,
                                                 12'h010, 12'h00C, 12'h00C, 12'h00C};
    localparam logic [7:0]  V_WD   [0:NV-1] = '{8'h12, 8'h1A, 8'h12, 8'hFF,
                                                 8'h00, 8'h02, 8'h35, 8'hC7};
    localparam logic [7:0]  V_RD   [0:NV-1] = '{8'h12, 8'h1A, 8'h12, 8'h12,
                                                 8'h12, 8'h02, 8'h35, 8'h07};
    localparam logic        V_CR   [0:NV-1] = '{1'b0, 1'b1, 1'b0, 1'b0,
                                                 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic        V_SR   [0:NV-1] = '{1'b0, 1'b0, 1'b0, 1'b0,
                                                 1'b0, 1'b1, 1'b0, 1'b1};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // counts negedges until the event is seen; 0 when not seen within lim
    task automatic wait_evt(input int lim, output int lat);
        lat = 0;
        for (int k = 1; k <= lim; k++) begin
            @(negedge clk);
            if (chg_evt_o) begin
                lat = k;
                break;
            end
        end
    endtask

    task automatic count_evts(input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (chg_evt_o) cnt++;
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int lat, n, pw;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        check("R3 evt after reset", {31'd0, chg_evt_o}, 32'd0);
        check("R10 absent after reset", {31'd0, present_o}, 32'd0);
        check("R6 card_rst after reset", {31'd0, card_rst_o}, 32'd0);
        check("R8 srst after reset", {31'd0, ctrl_srst_o}, 32'd1);
        rd(12'h00C, d); check("R7 opmode reset value", d, 32'h0);
        rd(12'h000, d); check("R9 status empty slot", d, 32'h0C);

        // register vector walk (R6 R7 R8)
        for (int i = 0; i < NV; i++) begin
            wr(V_ADDR[i], {24'h0, V_WD[i]});
            rd(12'h00C, d);
            check("R7 opmode readback", d, {24'h0, V_RD[i]});
            check("R6 card_rst level", {31'd0, card_rst_o}, {31'd0, V_CR[i]});
            check("R8 srst level", {31'd0, ctrl_srst_o}, {31'd0, V_SR[i]});
        end
        check("R7 mode field", {30'd0, mode_o}, 32'd3);
        wr(12'h00C, 32'h12);

        // R11 unmapped read
        rd(12'h020, d); check("R11 unmapped read", d, 32'h0);

        // R1 one pin only
        @(negedge clk); det_a_n = 1'b0;
        count_evts(20, n);
        check("R1 single pin no event", n, 0);
        check("R1 single pin not present", {31'd0, present_o}, 32'd0);
        det_a_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 glitch shorter than debounce
        det_a_n = 1'b0; det_b_n = 1'b0;
        repeat (DEB - 1) @(negedge clk);
        det_a_n = 1'b1; det_b_n = 1'b1;
        count_evts(20, n);
        check("R2 glitch ignored", n, 0);

        // insertion
        card_rdy_i = 1'b1; io_rdy_i = 1'b1;
        det_a_n = 1'b0; det_b_n = 1'b0;
        wait_evt(50, lat);
        check("R2 insert latency", lat, LAT);
        check("R3 present with event", {31'd0, present_o}, 32'd1);
        check("R4 reset starts with event", {31'd0, card_rst_o}, 32'd1);
        pw = 0;
        while (card_rst_o && pw < 100) begin
            pw++;
            @(negedge clk);
        end
        check("R4 pulse width", pw, RST);
        check("R3 single-cycle event", {31'd0, chg_evt_o}, 32'd0);
        count_evts(30, n);
        check("R3 no repeat while steady", n, 0);
        rd(12'h000, d); check("R9 status seated", d, 32'h61);

        // removal
        det_a_n = 1'b1;
        wait_evt(50, lat);
        check("R3 removal latency", lat, LAT);
        check("R3 absent after removal", {31'd0, present_o}, 32'd0);
        repeat (10) @(negedge clk);

        // R5 removal inside the insertion pulse
        det_a_n = 1'b0;
        wait_evt(50, lat);
        check("R5 second insert latency", lat, LAT);
        repeat (3) @(negedge clk);
        det_a_n = 1'b1; det_b_n = 1'b1;
        wait_evt(50, lat);
        check("R5 early removal latency", lat, LAT);
        check("R5 pulse cut short", {31'd0, card_rst_o}, 32'd0);
        check("R5 back to empty", {31'd0, present_o}, 32'd0);
        repeat (10) @(negedge clk);

        // R10 card present at power-up
        rst_n = 1'b0;
        det_a_n = 1'b0; det_b_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_evt(50, lat);
        check("R10 power-up insert latency", lat, LAT);
        count_evts(40, n);
        check("R10 single power-up event", n, 0);
        check("R10 present after power-up", {31'd0, present_o}, 32'd1);

        finish_run();
    end
endmodule